// File: doc/BRIEF.md
# Program Counter Sequencer with Single-Instruction Repeat

This block holds the program counter of a small processor and computes the next fetch address every clock. The decode stage supplies a decoded operation and its operands. The operation is one of: step to the next word, jump, subroutine entry, or subroutine exit. Any of the last three can be made conditional on a flag. On a subroutine entry the block keeps the address of the word after the entry. That address goes to one of three places. It can be pushed on an internal last-in-first-out stack. It can be offered on a link port so that an auxiliary register outside the block captures it. Or it can be written into a dedicated return register. A subroutine exit reads its address back from the same three places, chosen by the same select.

A repeat command loads a down-counter with an operand N. The word after the command then executes N+1 times. The PC stays on that word until the counter has drained to zero. While the counter is nonzero, every control strobe is ignored. The internal stack reports overflow and underflow through a sticky error flag. Reset is synchronous and loads a parameterised start address.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the next state has `pc_o` = RESET_VEC (default 0x000100), `rpt_cnt_o` = 0, `stk_depth_o` = 0, `stk_err_o` = 0 and `rpc_o` = 0.
- R2: With no repeat active, `rpt_i` = 0 and `op_i` = 0 (step), the PC advances by one, wrapping modulo 2^PCW.
- R3: A taken jump (`op_i` = 1) loads `target_i` into the PC. It leaves the stack, `rpc_o` and `link_we_o` untouched.
- R4: A taken subroutine entry (`op_i` = 2) loads `target_i` into the PC and saves PC+1 at the place selected by `ret_src_i`. For 0 or 3 the value is pushed on the stack. For 1 it is driven on `link_o` with `link_we_o` high in that same cycle. For 2 it is written into `rpc_o`.
- R5: A taken subroutine exit (`op_i` = 3) with `ret_src_i` = 1 loads `aux_ret_i` into the PC. With `ret_src_i` = 2 it loads the current `rpc_o`.
- R6: An operation with `is_cond_i` = 1 and `cond_i` = 0 behaves as a step. Nothing is saved, pushed or popped.
- R7: `rpt_i` with no repeat active loads `rpt_n_i` into the counter and advances the PC by one. In that cycle it takes priority over `op_i`.
- R8: While the counter is nonzero, the PC holds and the counter drops by one each cycle. The word after the repeat command is therefore current for N+1 cycles. The PC moves again once the counter reads 0.
- R9: While the counter is nonzero, `op_i`, `rpt_i` and the condition inputs have no effect on the PC, stack, `rpc_o` or `link_we_o`.
- R10: A stack-saving entry with STK_DEPTH (8) entries in use still loads the target into the PC. It pushes nothing and sets `stk_err_o`, which stays set until reset.
- R11: A stack-sourced exit on an empty stack advances the PC by one and sets `stk_err_o`.
- R12: A stack-sourced exit (`ret_src_i` 0 or 3) on a non-empty stack loads the most recently pushed address and lowers the depth by one (last in, first out).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Decoded operation: 0 step, 1 jump, 2 subroutine entry, 3 subroutine exit |
| is_cond_i | input | 1 | Operation is conditional |
| cond_i | input | 1 | Condition outcome for a conditional operation |
| ret_src_i | input | 2 | Return address place: 0/3 stack, 1 auxiliary, 2 return register |
| target_i | input | PCW | Jump or entry target |
| aux_ret_i | input | PCW | Return address from the auxiliary register |
| rpt_i | input | 1 | Repeat command |
| rpt_n_i | input | CW | Repeat operand N |
| pc_o | output | PCW | Current program counter |
| rpt_cnt_o | output | CW | Remaining repeat count |
| rpt_active_o | output | 1 | Repeat counter nonzero |
| link_o | output | PCW | Address following the current PC |
| link_we_o | output | 1 | Write strobe for the auxiliary register |
| rpc_o | output | PCW | Return register contents |
| stk_depth_o | output | $clog2(STK_DEPTH+1) | Entries in use on the stack |
| stk_err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
Random operation streams mix all four operations with every return select and random condition outcomes. A wrong select decode or a missed condition shows up as a PC, depth or return register mismatch against a reference model. Short random repeat operands, with strobes still arriving during the repeat, separate a correct hold-and-drain from an off-by-one count or a strobe leaking through. Directed runs fill the stack past its depth, drain it below empty, and nest pushes and pops. These runs tell push order, full and empty handling and error stickiness apart.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        OP_STEP   = 2'd0,
        OP_JUMP   = 2'd1,
        OP_ENTER  = 2'd2,
        OP_EXIT   = 2'd3
    } pcs_op_e;

    typedef enum logic [1:0] {
        SRC_STACK     = 2'd0,
        SRC_AUX       = 2'd1,
        SRC_RETREG    = 2'd2,
        SRC_STACK_ALT = 2'd3
    } pcs_src_e;

    function automatic logic src_is_stack(input logic [1:0] s);
        return (s == SRC_STACK) || (s == SRC_STACK_ALT);
    endfunction

endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int AW    = 22,
    parameter int DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH + 1)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [AW-1:0]   wdata_i,
    output logic [AW-1:0]   top_o,
    output logic [PTRW-1:0] depth_o,
    output logic            empty_o,
    output logic            err_o
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] mem;
        logic [PTRW-1:0]          depth;
        logic                     err;
    } stk_state_t;

    stk_state_t st_d, st_q;

    logic full, empty, push_ok, pop_ok;

    assign full    = (st_q.depth == PTRW'(DEPTH));
    assign empty   = (st_q.depth == '0);
    assign push_ok = push_i && !full;
    assign pop_ok  = pop_i && !empty;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && (st_q.depth == PTRW'(i))) begin
                st_d.mem[i] = wdata_i;
            end
        end
        if (push_ok) begin
            st_d.depth = st_q.depth + 1'b1;
        end else if (pop_ok) begin
            st_d.depth = st_q.depth - 1'b1;
        end
        if ((push_i && full) || (pop_i && empty)) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        top_o = st_q.mem[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (st_q.depth == PTRW'(i + 1)) begin
                top_o = st_q.mem[i];
            end
        end
    end

    assign depth_o = st_q.depth;
    assign empty_o = empty;
    assign err_o   = st_q.err;

endmodule

// File: rtl/pcs_repeat_ctr.sv
module pcs_repeat_ctr #(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          active_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          active;

    assign active = (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (active) begin
            cnt_d = cnt_q - 1'b1;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign active_o = active;

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pcs_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic [AW-1:0] pc_i,
    input  logic [1:0]    op_i,
    input  logic          is_cond_i,
    input  logic          cond_i,
    input  logic [1:0]    src_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] aux_ret_i,
    input  logic [AW-1:0] rpc_i,
    input  logic [AW-1:0] stk_top_i,
    input  logic          stk_empty_i,
    input  logic          rpt_active_i,
    input  logic          rpt_req_i,
    output logic [AW-1:0] pc_next_o,
    output logic [AW-1:0] seq_o,
    output logic          push_o,
    output logic          pop_o,
    output logic          rpc_load_o,
    output logic          link_we_o,
    output logic          rpt_load_o
);

    logic take, ctl_ok, from_stack;

    assign seq_o      = pc_i + 1'b1;
    assign take       = !is_cond_i || cond_i;
    assign ctl_ok     = !rpt_active_i && !rpt_req_i && take;
    assign from_stack = src_is_stack(src_i);

    always_comb begin
        pc_next_o  = seq_o;
        push_o     = 1'b0;
        pop_o      = 1'b0;
        rpc_load_o = 1'b0;
        link_we_o  = 1'b0;
        rpt_load_o = rpt_req_i && !rpt_active_i;

        if (rpt_active_i) begin
            pc_next_o = pc_i;
        end else if (ctl_ok) begin
            unique case (pcs_op_e'(op_i))
                OP_STEP: begin
                    pc_next_o = seq_o;
                end
                OP_JUMP: begin
                    pc_next_o = target_i;
                end
                OP_ENTER: begin
                    pc_next_o = target_i;
                    if (from_stack) begin
                        push_o = 1'b1;
                    end else if (src_i == SRC_AUX) begin
                        link_we_o = 1'b1;
                    end else begin
                        rpc_load_o = 1'b1;
                    end
                end
                OP_EXIT: begin
                    if (from_stack) begin
                        pop_o     = 1'b1;
                        pc_next_o = stk_empty_i ? seq_o : stk_top_i;
                    end else if (src_i == SRC_AUX) begin
                        pc_next_o = aux_ret_i;
                    end else begin
                        pc_next_o = rpc_i;
                    end
                end
                default: pc_next_o = seq_o;
            endcase
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int              PCW       = 22,
    parameter int              STK_DEPTH = 8,
    parameter int              CW        = 16,
    parameter logic [PCW-1:0]  RESET_VEC = PCW'(32'h100),
    localparam int             SPW       = $clog2(STK_DEPTH + 1)
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [1:0]     op_i,
    input  logic           is_cond_i,
    input  logic           cond_i,
    input  logic [1:0]     ret_src_i,
    input  logic [PCW-1:0] target_i,
    input  logic [PCW-1:0] aux_ret_i,
    input  logic           rpt_i,
    input  logic [CW-1:0]  rpt_n_i,
    output logic [PCW-1:0] pc_o,
    output logic [CW-1:0]  rpt_cnt_o,
    output logic           rpt_active_o,
    output logic [PCW-1:0] link_o,
    output logic           link_we_o,
    output logic [PCW-1:0] rpc_o,
    output logic [SPW-1:0] stk_depth_o,
    output logic           stk_err_o
);

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [PCW-1:0] rpc;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [PCW-1:0] pc_next, seq_addr, stk_top;
    logic           push, pop, rpc_load, rpt_load;
    logic           stk_empty, rpt_active;
    logic [CW-1:0]  rpt_cnt;

    pcs_next_pc #(.AW(PCW)) u_next (
        .pc_i         (st_q.pc),
        .op_i         (op_i),
        .is_cond_i    (is_cond_i),
        .cond_i       (cond_i),
        .src_i        (ret_src_i),
        .target_i     (target_i),
        .aux_ret_i    (aux_ret_i),
        .rpc_i        (st_q.rpc),
        .stk_top_i    (stk_top),
        .stk_empty_i  (stk_empty),
        .rpt_active_i (rpt_active),
        .rpt_req_i    (rpt_i),
        .pc_next_o    (pc_next),
        .seq_o        (seq_addr),
        .push_o       (push),
        .pop_o        (pop),
        .rpc_load_o   (rpc_load),
        .link_we_o    (link_we_o),
        .rpt_load_o   (rpt_load)
    );

    pcs_ret_stack #(.AW(PCW), .DEPTH(STK_DEPTH)) u_stack (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (seq_addr),
        .top_o   (stk_top),
        .depth_o (stk_depth_o),
        .empty_o (stk_empty),
        .err_o   (stk_err_o)
    );

    pcs_repeat_ctr #(.CW(CW)) u_repeat (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (rpt_load),
        .load_val_i (rpt_n_i),
        .cnt_o      (rpt_cnt),
        .active_o   (rpt_active)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_next;
        if (rpc_load) begin
            st_d.rpc = seq_addr;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.pc  <= RESET_VEC;
            st_q.rpc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o         = st_q.pc;
    assign rpc_o        = st_q.rpc;
    assign link_o       = seq_addr;
    assign rpt_cnt_o    = rpt_cnt;
    assign rpt_active_o = rpt_active;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int PCW       = 22,
    parameter int STK_DEPTH = 8,
    parameter int CW        = 16,
    parameter int SPW       = 4
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic [1:0]     op_i,
    input logic           is_cond_i,
    input logic           cond_i,
    input logic [1:0]     ret_src_i,
    input logic [PCW-1:0] target_i,
    input logic           rpt_i,
    input logic [PCW-1:0] pc_o,
    input logic [CW-1:0]  rpt_cnt_o,
    input logic [PCW-1:0] link_o,
    input logic           link_we_o,
    input logic [PCW-1:0] rpc_o,
    input logic [SPW-1:0] stk_depth_o,
    input logic           stk_err_o
);

    logic quiet, take, stk_sel;
    assign quiet   = (rpt_cnt_o == '0) && !rpt_i;
    assign take    = !is_cond_i || cond_i;
    assign stk_sel = (ret_src_i == 2'd0) || (ret_src_i == 2'd3);

    assert_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && op_i == 2'd0) |=> pc_o == $past(pc_o) + 1'b1);

    assert_jump_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && op_i == 2'd1 && take) |=> (pc_o == $past(target_i)) && $stable(stk_depth_o) && $stable(rpc_o));

    assert_link_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        link_we_o |-> (op_i == 2'd2 && ret_src_i == 2'd1 && link_o == pc_o + 1'b1));

    assert_rpc_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && op_i == 2'd2 && take && ret_src_i == 2'd2) |=> rpc_o == $past(pc_o) + 1'b1);

    assert_skip_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && is_cond_i && !cond_i) |=> (pc_o == $past(pc_o) + 1'b1) && $stable(stk_depth_o));

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rpt_cnt_o != '0) |=> $stable(pc_o) && rpt_cnt_o == $past(rpt_cnt_o) - 1'b1);

    assert_ignore_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rpt_cnt_o != '0) |-> !link_we_o);

    assert_overflow_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && op_i == 2'd2 && take && stk_sel && stk_depth_o == SPW'(STK_DEPTH))
        |=> stk_err_o && $stable(stk_depth_o));

    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        stk_err_o |=> stk_err_o);

    assert_bound_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        stk_depth_o <= SPW'(STK_DEPTH));

endmodule

bind pc_sequencer pcs_checker #(
    .PCW(PCW), .STK_DEPTH(STK_DEPTH), .CW(CW), .SPW(SPW)
) u_pcs_checker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .op_i        (op_i),
    .is_cond_i   (is_cond_i),
    .cond_i      (cond_i),
    .ret_src_i   (ret_src_i),
    .target_i    (target_i),
    .rpt_i       (rpt_i),
    .pc_o        (pc_o),
    .rpt_cnt_o   (rpt_cnt_o),
    .link_o      (link_o),
    .link_we_o   (link_we_o),
    .rpc_o       (rpc_o),
    .stk_depth_o (stk_depth_o),
    .stk_err_o   (stk_err_o)
);

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;

    localparam int PCW       = 22;
    localparam int STK_DEPTH = 8;
    localparam int CW        = 16;
    localparam int SPW       = $clog2(STK_DEPTH + 1);
    localparam logic [PCW-1:0] RESET_VEC = PCW'(32'h100);
    localparam time CLK_PERIOD = 10ns;
    localparam int  SEED = 32'h5EC1;

    logic           clk = 1'b0;
    logic           rst_i;
    logic [1:0]     op_i;
    logic           is_cond_i;
    logic           cond_i;
    logic [1:0]     ret_src_i;
    logic [PCW-1:0] target_i;
    logic [PCW-1:0] aux_ret_i;
    logic           rpt_i;
    logic [CW-1:0]  rpt_n_i;
    logic [PCW-1:0] pc_o;
    logic [CW-1:0]  rpt_cnt_o;
    logic           rpt_active_o;
    logic [PCW-1:0] link_o;
    logic           link_we_o;
    logic [PCW-1:0] rpc_o;
    logic [SPW-1:0] stk_depth_o;
    logic           stk_err_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pc_sequencer #(.PCW(PCW), .STK_DEPTH(STK_DEPTH), .CW(CW), .RESET_VEC(RESET_VEC)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .op_i(op_i), .is_cond_i(is_cond_i), .cond_i(cond_i),
        .ret_src_i(ret_src_i), .target_i(target_i), .aux_ret_i(aux_ret_i), .rpt_i(rpt_i),
        .rpt_n_i(rpt_n_i), .pc_o(pc_o), .rpt_cnt_o(rpt_cnt_o), .rpt_active_o(rpt_active_o),
        .link_o(link_o), .link_we_o(link_we_o), .rpc_o(rpc_o), .stk_depth_o(stk_depth_o),
        .stk_err_o(stk_err_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [PCW-1:0] m_pc, m_rpc, m_link;
    logic [CW-1:0]  m_cnt;
    logic [PCW-1:0] m_stk [STK_DEPTH];
    int             m_depth;
    logic           m_err, m_link_we;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string model_step();
        logic [PCW-1:0] nx;
        logic take;
        logic stk;
        string tag;
        nx = m_pc + 1'b1;
        m_link = nx;
        m_link_we = 1'b0;
        take = !is_cond_i || cond_i;
        stk = (ret_src_i == 2'd0) || (ret_src_i == 2'd3);
        if (m_cnt != 0) begin
            m_cnt = m_cnt - 1'b1;
            tag = (op_i != 2'd0 || rpt_i) ? "R9" : "R8";
        end else if (rpt_i) begin
            m_cnt = rpt_n_i;
            m_pc = nx;
            tag = "R7";
        end else if (op_i == 2'd0) begin
            m_pc = nx; tag = "R2";
        end else if (!take) begin
            m_pc = nx; tag = "R6";
        end else if (op_i == 2'd1) begin
            m_pc = target_i; tag = "R3";
        end else if (op_i == 2'd2) begin
            m_pc = target_i;
            tag = "R4";
            if (stk) begin
                if (m_depth == STK_DEPTH) begin
                    m_err = 1'b1; tag = "R10";
                end else begin
                    m_stk[m_depth] = nx; m_depth++;
                end
            end else if (ret_src_i == 2'd1) begin
                m_link_we = 1'b1;
            end else begin
                m_rpc = nx;
            end
        end else begin
            if (stk) begin
                if (m_depth == 0) begin
                    m_err = 1'b1; m_pc = nx; tag = "R11";
                end else begin
                    m_depth--; m_pc = m_stk[m_depth]; tag = "R12";
                end
            end else if (ret_src_i == 2'd1) begin
                m_pc = aux_ret_i; tag = "R5";
            end else begin
                m_pc = m_rpc; tag = "R5";
            end
        end
        return tag;
    endfunction

    // called at a falling edge; applies inputs, checks combinational outputs, then registered ones
    task automatic step(input logic [1:0] op, input logic isc, input logic cnd, input logic [1:0] src,
                        input logic [PCW-1:0] tgt, input logic [PCW-1:0] aux,
                        input logic rpt, input logic [CW-1:0] n);
        string tag;
        op_i = op; is_cond_i = isc; cond_i = cnd; ret_src_i = src;
        target_i = tgt; aux_ret_i = aux; rpt_i = rpt; rpt_n_i = n;
        #1;
        tag = model_step();
        chk(tag, "link_we", 32'(link_we_o), 32'(m_link_we));
        chk(tag, "link", 32'(link_o), 32'(m_link));
        @(posedge clk);
        @(negedge clk);
        chk(tag, "pc", 32'(pc_o), 32'(m_pc));
        chk(tag, "rpt_cnt", 32'(rpt_cnt_o), 32'(m_cnt));
        chk(tag, "rpt_active", 32'(rpt_active_o), 32'(m_cnt != 0));
        chk(tag, "depth", 32'(stk_depth_o), 32'(m_depth));
        chk(tag, "err", 32'(stk_err_o), 32'(m_err));
        chk(tag, "rpc", 32'(rpc_o), 32'(m_rpc));
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        op_i = 2'd0; is_cond_i = 1'b0; cond_i = 1'b0; ret_src_i = 2'd0;
        target_i = '0; aux_ret_i = '0; rpt_i = 1'b0; rpt_n_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_i = 1'b0;
        m_pc = RESET_VEC; m_rpc = '0; m_cnt = '0; m_depth = 0; m_err = 1'b0;
        chk("R1", "pc", 32'(pc_o), 32'(RESET_VEC));
        chk("R1", "rpt_cnt", 32'(rpt_cnt_o), 32'd0);
        chk("R1", "depth", 32'(stk_depth_o), 32'd0);
        chk("R1", "err", 32'(stk_err_o), 32'd0);
        chk("R1", "rpc", 32'(rpc_o), 32'd0);
    endtask

    task automatic rand_step();
        logic [1:0] op;
        op = 2'($urandom % 4);
        step(op, ($urandom % 3) == 0, 1'($urandom % 2), 2'($urandom % 4),
             PCW'($urandom), PCW'($urandom), ($urandom % 10) == 0, CW'($urandom % 6));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(SEED);
        do_reset();

        // R2: wrap at the top of the address space
        step(2'd1, 1'b0, 1'b0, 2'd0, {PCW{1'b1}}, '0, 1'b0, '0);
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);

        // R4 / R5: every save place and its matching exit
        step(2'd2, 1'b0, 1'b0, 2'd2, PCW'(32'h2000), '0, 1'b0, '0);
        step(2'd3, 1'b0, 1'b0, 2'd2, '0, '0, 1'b0, '0);
        step(2'd2, 1'b0, 1'b0, 2'd1, PCW'(32'h3000), '0, 1'b0, '0);
        step(2'd3, 1'b0, 1'b0, 2'd1, '0, PCW'(32'h3456), 1'b0, '0);

        // R6: conditional operations not taken
        step(2'd2, 1'b1, 1'b0, 2'd0, PCW'(32'h4000), '0, 1'b0, '0);
        step(2'd3, 1'b1, 1'b0, 2'd2, '0, '0, 1'b0, '0);

        // R7, R8, R9: repeat with N = 3, strobes arriving while active
        step(2'd1, 1'b0, 1'b0, 2'd0, PCW'(32'h5000), '0, 1'b1, CW'(3));
        step(2'd1, 1'b0, 1'b0, 2'd0, PCW'(32'h6000), '0, 1'b1, CW'(7));
        step(2'd2, 1'b0, 1'b0, 2'd1, PCW'(32'h6000), '0, 1'b0, '0);
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);
        // R7: repeat with N = 0 executes once
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b1, CW'(0));
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);

        // R12 and R10: fill past depth, then drain; R11 below empty
        for (int i = 0; i < STK_DEPTH + 1; i++) begin
            step(2'd2, 1'b0, 1'b0, 2'(i % 2 ? 0 : 3), PCW'(32'h10000 + i * 32'h100), '0, 1'b0, '0);
        end
        for (int i = 0; i < STK_DEPTH + 1; i++) begin
            step(2'd3, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);
        end
        step(2'd0, 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);

        // R1 again, then random traffic
        do_reset();
        for (int i = 0; i < 1500; i++) rand_step();
        do_reset();
        for (int i = 0; i < 1500; i++) rand_step();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule